// File: doc/BRIEF.md
# Flag Offset Byte-Load Sequencer

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. Each offset is stored as a pair of byte registers, so there are four byte registers in total. A software agent or a neighbouring controller loads them by presenting bytes on the data input while holding the write enable and the load pin low. Each qualifying write-clock edge stores the byte in the next register of a fixed rotation. The assembled offsets leave the block as two buses that are sized to the FIFO's address width.

A second pointer, clocked by the read clock, walks the same four registers in the same rotation. This lets the stored bytes be read back one at a time. Loading and read-back are honoured only while the latched mode bit selects programmable flags. Reset restores both offsets to their default of 7 and returns both pointers to the first register.

Top module: `ofs_load_seq`

## Requirements
- R1: While reset is low and immediately after it is released, empty_ofs and full_ofs both read 7. Both the load pointer and the read-back pointer rest on slot 0, so rb_data reads 7 and the next load writes slot 0.
- R2: A byte is stored only on a rising wclk edge where prog_mode=1, wen1_n=0 and ld_n=0. On an edge where wen1_n=1 or ld_n=1, neither offset changes.
- R3: Successive stores go to slot 0 (empty_ofs bits 7:0), slot 1 (empty_ofs bits 15:8), slot 2 (full_ofs bits 7:0) and slot 3 (full_ofs bits 15:8), in that order. The new value is visible right after the storing edge.
- R4: The store after slot 3 wraps back to slot 0.
- R5: A wclk edge that stores nothing leaves the load pointer where it was. The next store continues the rotation from that slot.
- R6: Only din[7:0] is stored. din[8] has no effect on either offset.
- R7: Each offset equals {high byte, low byte} truncated to its low DEPTH_BITS bits (13 by default). A high byte of 8'hFF with a low byte of 8'h30 therefore gives 13'h1F30.
- R8: rb_data shows the register at the read-back pointer. Each rising rclk edge with prog_mode=1 and rb_n=0 advances that pointer in the order slot 0, 1, 2, 3, 0. When rb_n=1, the pointer holds.
- R9: With prog_mode=0, load edges change neither offset and do not move the load pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; loads happen on its rising edge |
| rclk | input | 1 | Read clock; advances the read-back pointer |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Latched mode bit; 1 selects programmable flags |
| wen1_n | input | 1 | Active-low write enable |
| ld_n | input | 1 | Active-low load select |
| din | input | DATA_W (9) | Data input; the low byte is stored |
| rb_n | input | 1 | Active-low read-back advance |
| empty_ofs | output | DEPTH_BITS (13) | Almost-empty offset |
| full_ofs | output | DEPTH_BITS (13) | Almost-full offset |
| rb_data | output | BYTE_W (8) | Byte at the read-back pointer |

## Verification
Every store lands on the wclk edge that samples the load condition, so both offsets are due one edge after the inputs are set up. The bench drives its inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge against a four-byte reference model. rb_data is combinational from a pointer that moves on the rclk edge. The bench therefore reads it on the falling edge before each advance pulse and again on the falling edge after the pulse. Any edge that should store nothing is followed by a check of both offsets before the next stimulus arrives.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;
    localparam int unsigned NUM_SLOTS = 4;

    // slot order is behaviour: rotation and read-back follow it
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;
endpackage

// File: rtl/ofs_slot_ctr.sv
module ofs_slot_ctr
    import ofsld_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output slot_e slot
);
    typedef struct packed {
        slot_e slot;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.slot = slot_e'(st_q.slot + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= SLOT_E_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofsld_pkg::*;
#(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned DEF_OFS = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  slot_e                               slot,
    input  logic [BYTE_W-1:0]                   wbyte,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]    regs
);
    localparam int unsigned PAIR_W = 2 * BYTE_W;
    localparam logic [PAIR_W-1:0] DEF_PAIR = PAIR_W'(DEF_OFS);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][BYTE_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.regs[slot] = wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= {DEF_PAIR, DEF_PAIR};
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.regs;
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
    import ofsld_pkg::*;
#(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned DEPTH_BITS = 13,
    parameter int unsigned DEF_OFS    = 7
) (
    input  logic                  wclk,
    input  logic                  rclk,
    input  logic                  rst_n,
    input  logic                  prog_mode,
    input  logic                  wen1_n,
    input  logic                  ld_n,
    input  logic [DATA_W-1:0]     din,
    input  logic                  rb_n,
    output logic [DEPTH_BITS-1:0] empty_ofs,
    output logic [DEPTH_BITS-1:0] full_ofs,
    output logic [BYTE_W-1:0]     rb_data
);
    localparam int unsigned PAIR_W = 2 * BYTE_W;

    logic                             load;
    logic                             rb_adv;
    slot_e                            wr_slot;
    slot_e                            rd_slot;
    logic [NUM_SLOTS-1:0][BYTE_W-1:0] bytes;
    logic [PAIR_W-1:0]                empty_pair;
    logic [PAIR_W-1:0]                full_pair;

    assign load   = prog_mode & ~wen1_n & ~ld_n;
    assign rb_adv = prog_mode & ~rb_n;

    ofs_slot_ctr i_wr_ctr (
        .clk  (wclk),
        .rst_n(rst_n),
        .adv  (load),
        .slot (wr_slot)
    );

    ofs_slot_ctr i_rd_ctr (
        .clk  (rclk),
        .rst_n(rst_n),
        .adv  (rb_adv),
        .slot (rd_slot)
    );

    ofs_bank #(
        .BYTE_W (BYTE_W),
        .DEF_OFS(DEF_OFS)
    ) i_bank (
        .clk  (wclk),
        .rst_n(rst_n),
        .we   (load),
        .slot (wr_slot),
        .wbyte(din[BYTE_W-1:0]),
        .regs (bytes)
    );

    assign empty_pair = {bytes[SLOT_E_HI], bytes[SLOT_E_LO]};
    assign full_pair  = {bytes[SLOT_F_HI], bytes[SLOT_F_LO]};
    assign empty_ofs  = empty_pair[DEPTH_BITS-1:0];
    assign full_ofs   = full_pair[DEPTH_BITS-1:0];
    assign rb_data    = bytes[rd_slot];

    // data bits above the byte are never stored
    generate
        if (DATA_W > BYTE_W) begin : g_din_extra
            logic unused_din_hi;
            assign unused_din_hi = ^din[DATA_W-1:BYTE_W];
        end
        if (PAIR_W > DEPTH_BITS) begin : g_pair_extra
            logic unused_pair_hi;
            assign unused_pair_hi = ^{empty_pair[PAIR_W-1:DEPTH_BITS],
                                      full_pair[PAIR_W-1:DEPTH_BITS]};
        end
    endgenerate
endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk
    import ofsld_pkg::*;
#(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned DEPTH_BITS = 13,
    parameter int unsigned DEF_OFS    = 7
) (
    input logic                  wclk,
    input logic                  rclk,
    input logic                  rst_n,
    input logic                  prog_mode,
    input logic                  wen1_n,
    input logic                  ld_n,
    input logic [DATA_W-1:0]     din,
    input logic                  rb_n,
    input logic [DEPTH_BITS-1:0] empty_ofs,
    input logic [DEPTH_BITS-1:0] full_ofs,
    input slot_e                 wr_slot,
    input slot_e                 rd_slot
);
    localparam logic [DEPTH_BITS-1:0] DEF_V = DEPTH_BITS'(DEF_OFS);

    assert_reset_default_R1: assert property (@(posedge wclk)
        $rose(rst_n) |-> (empty_ofs == DEF_V && full_ofs == DEF_V
                          && wr_slot == SLOT_E_LO));

    assert_no_load_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen1_n || ld_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_full_lo_byte_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (prog_mode && !wen1_n && !ld_n && wr_slot == SLOT_F_LO)
        |=> full_ofs[BYTE_W-1:0] == $past(din[BYTE_W-1:0]));

    assert_wrap_R4: assert property (@(posedge wclk) disable iff (!rst_n)
        (prog_mode && !wen1_n && !ld_n && wr_slot == SLOT_F_HI)
        |=> wr_slot == SLOT_E_LO);

    assert_ptr_hold_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen1_n || ld_n) |=> $stable(wr_slot));

    assert_mode_off_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        !prog_mode |=> ($stable(wr_slot) && $stable(empty_ofs) && $stable(full_ofs)));

    assert_rb_step_R8: assert property (@(posedge rclk) disable iff (!rst_n)
        (prog_mode && !rb_n) |=> rd_slot == slot_e'($past(rd_slot) + 2'd1));
endmodule

bind ofs_load_seq ofs_load_seq_chk #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .DEPTH_BITS(DEPTH_BITS),
    .DEF_OFS   (DEF_OFS)
) i_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .prog_mode(prog_mode),
    .wen1_n   (wen1_n),
    .ld_n     (ld_n),
    .din      (din),
    .rb_n     (rb_n),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs),
    .wr_slot  (wr_slot),
    .rd_slot  (rd_slot)
);

// File: tb/test_ofs_load_seq.sv
module test_ofs_load_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b1;
    logic        wen1_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [8:0]  din = '0;
    logic        rb_n = 1'b1;
    logic [12:0] empty_ofs, full_ofs;
    logic [7:0]  rb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] mdl [4];
    int         mptr = 0;

    always #4 clk = ~clk;

    ofs_load_seq i_ofs_load_seq (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
        .wen1_n(wen1_n), .ld_n(ld_n), .din(din), .rb_n(rb_n),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rb_data(rb_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] e_exp();
        return {mdl[1], mdl[0]} & 16'h1FFF;
    endfunction
    function automatic logic [12:0] f_exp();
        return {mdl[3], mdl[2]} & 16'h1FFF;
    endfunction

    task automatic model_reset();
        mdl[0] = 8'd7; mdl[1] = 8'd0; mdl[2] = 8'd7; mdl[3] = 8'd0;
        mptr = 0;
    endtask

    task automatic chk_offsets(input string req);
        chk({req, " empty"}, {3'b0, empty_ofs}, {3'b0, e_exp()});
        chk({req, " full"},  {3'b0, full_ofs},  {3'b0, f_exp()});
    endtask

    // one edge with given pins; model follows the requirement
    task automatic edge_drive(input logic w, input logic l, input logic [8:0] d,
                              input string req);
        @(negedge clk);
        wen1_n = w; ld_n = l; din = d;
        @(negedge clk);
        if (prog_mode && !w && !l) begin
            mdl[mptr] = d[7:0];
            mptr = (mptr + 1) % 4;
        end
        wen1_n = 1'b1; ld_n = 1'b1;
        chk_offsets(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1 during reset", {3'b0, empty_ofs}, 16'd7);
        chk("R1 during reset full", {3'b0, full_ofs}, 16'd7);
        rst_n = 1'b1;
        @(negedge clk);
        chk_offsets("R1 after release");
        chk("R1 readback slot0", {8'b0, rb_data}, 16'd7);
    endtask

    task automatic t_order();
        edge_drive(1'b0, 1'b0, 9'h011, "R3 empty lo");
        edge_drive(1'b0, 1'b0, 9'h005, "R3 empty hi");
        edge_drive(1'b0, 1'b0, 9'h022, "R3 full lo");
        edge_drive(1'b0, 1'b0, 9'h003, "R3 full hi");
        chk("R3 full value", {3'b0, full_ofs}, 16'h0322);
    endtask

    task automatic t_wrap();
        edge_drive(1'b0, 1'b0, 9'h044, "R4 fifth load");
        chk("R4 wrap value", {3'b0, empty_ofs}, 16'h0544);
    endtask

    task automatic t_idle();
        edge_drive(1'b0, 1'b1, 9'h0AA, "R2 ld high");
        edge_drive(1'b1, 1'b0, 9'h0BB, "R2 wen high");
        edge_drive(1'b1, 1'b1, 9'h0CC, "R5 idle");
        edge_drive(1'b0, 1'b0, 9'h006, "R5 resume at empty hi");
        chk("R5 value", {3'b0, empty_ofs}, 16'h0644);
    endtask

    task automatic t_mode();
        prog_mode = 1'b0;
        edge_drive(1'b0, 1'b0, 9'h099, "R9 mode off");
        prog_mode = 1'b1;
        edge_drive(1'b0, 1'b0, 9'h030, "R9 pointer kept");
        chk("R9 full lo", {3'b0, full_ofs}, 16'h0330);
    endtask

    task automatic t_width();
        edge_drive(1'b0, 1'b0, 9'h1FF, "R6 bit8 full hi");
        chk("R7 truncate", {3'b0, full_ofs}, 16'h1F30);
        edge_drive(1'b0, 1'b0, 9'h100, "R6 bit8 only");
        chk("R6 empty lo", {3'b0, empty_ofs}, 16'h0600);
    endtask

    task automatic t_readback();
        @(negedge clk);
        chk("R8 hold", {8'b0, rb_data}, {8'b0, mdl[0]});
        for (int i = 0; i < 5; i++) begin
            chk("R8 slot", {8'b0, rb_data}, {8'b0, mdl[i % 4]});
            rb_n = 1'b0;
            @(negedge clk);
            rb_n = 1'b1;
        end
        @(negedge clk);
        chk("R8 after wrap", {8'b0, rb_data}, {8'b0, mdl[1]});
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        t_reset();
        edge_drive(1'b0, 1'b0, 9'h009, "R1 pointer at slot0");
        chk("R1 reload", {3'b0, empty_ofs}, 16'h0009);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_order();
        t_wrap();
        t_idle();
        t_mode();
        t_width();
        t_readback();
        t_reset_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule